// File: doc/BRIEF.md
# Strobe-Qualified Serial Byte Port

A serial front end that moves bytes between a parallel handshake interface and a pair of serial lines, one for each direction. Both directions run from a single externally supplied bit clock. The block generates no clock of its own. A receive strobe picks which clock edges sample the incoming line. A transmit strobe picks which clock edges advance the outgoing line. Because each direction has its own strobe, the line can carry data only in chosen time slots, and the receive and transmit effective rates can differ while the clock is shared.

A mode input selects how the strobes are read. In per-bit mode, every bit needs its own strobe edge. In byte mode, one strobe edge carries bit 0 of a new byte, the seven following edges carry the rest of that byte without further strobes, and the strobe therefore also marks the byte boundary. Bits travel least significant first. A received byte waits in a holding register until the consumer takes it. A byte to send waits in a one-entry buffer until its slot begins.

Top module: `strobe_serial_if`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `tx_line` is 1, `tx_ready` is 1, and `rx_valid`, `rx_overrun` and `tx_underrun` are 0. Both bit counters restart at bit 0.
- R2: Serial bits are least significant first: the first qualified receive bit lands in `rx_byte[0]`, and the first bit driven for a loaded byte is `tx_byte[0]`.
- R3: In per-bit mode (`byte_mode`=0), `rx_din` is sampled only on edges where `rx_strobe` is 1. `rx_valid` is 1 right after the edge that samples the eighth such bit, and never rises after an edge without `rx_strobe`.
- R4: In per-bit mode, `tx_line` changes only on edges where `tx_strobe` is 1. Each such edge drives the next bit, and other edges hold the line.
- R5: In byte mode (`byte_mode`=1), a strobe edge seen while no byte is in progress carries bit 0. The seven following edges carry bits 1 to 7, whatever the strobe does, in both directions.
- R6: In byte mode, a strobe that arrives while a byte is in progress has no effect on that byte or on its alignment.
- R7: `rx_valid` stays 1 and `rx_byte` stays stable until an edge with `rx_ready` 1. If a new byte completes on the same edge that the held byte is taken, the new byte is loaded and no overrun is flagged.
- R8: If a byte completes while `rx_valid` is 1 and `rx_ready` is 0, the new byte is dropped and the held byte is kept. `rx_overrun` is then set and stays set until an edge with `ovr_clear` 1. If a drop and a clear fall on the same edge, the flag is set.
- R9: `tx_ready` is 1 exactly when the transmit buffer is empty. An edge with `tx_valid` and `tx_ready` both 1 loads `tx_byte` and drops `tx_ready` until that byte's slot starts.
- R10: When a byte slot starts with the buffer empty, the slot carries eight 1 bits. `tx_underrun` is 1 for exactly the one cycle in which the first of those bits is on `tx_line`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | External bit clock shared by both directions |
| rst | input | 1 | Synchronous active-high reset |
| byte_mode | input | 1 | 0: strobe per bit, 1: strobe once per byte |
| rx_din | input | 1 | Serial receive data |
| rx_strobe | input | 1 | Receive sampling qualifier |
| rx_byte | output | W | Received byte held for the consumer |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer takes the held byte |
| ovr_clear | input | 1 | Clears the overrun flag |
| rx_overrun | output | 1 | Sticky flag: a received byte was dropped |
| tx_strobe | input | 1 | Transmit shifting qualifier |
| tx_byte | input | W | Byte to send |
| tx_valid | input | 1 | Producer offers `tx_byte` |
| tx_ready | output | 1 | Transmit buffer empty |
| tx_line | output | 1 | Serial transmit data, idle high |
| tx_underrun | output | 1 | One-cycle pulse: slot started without data |

## Verification
The delicate coincidence is a received byte completing on the same edge that the consumer takes the held byte. The correct outcome there is a clean swap with no overrun. The bench provokes this by raising `rx_ready` only during the cycle of the eighth bit of a byte-mode transfer, and it judges the result by the new `rx_byte`, a high `rx_valid` and a low `rx_overrun`. A second collision, a transmit load on the edge where an empty slot starts, is left to the random phases. There the behavioural model requires an underrun pulse and keeps the freshly loaded byte for the next slot.

// File: rtl/ssi_pkg.sv
`timescale 1ns/1ps
package ssi_pkg;

  // How a strobe is interpreted by a slot counter.
  typedef enum logic {
    MODE_PER_BIT = 1'b0,
    MODE_BYTE    = 1'b1
  } strobe_mode_e;

endpackage

// File: rtl/ssi_slot_gate.sv
`timescale 1ns/1ps
// Decides on which edges a serial bit moves and tracks the bit index.
module ssi_slot_gate #(
  parameter int W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  ssi_pkg::strobe_mode_e  mode,
  input  logic                   strobe,
  output logic                   take,
  output logic [$clog2(W)-1:0]   idx
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

  logic [CW-1:0] cnt_q;
  logic          mid_byte;

  assign mid_byte = (cnt_q != '0);
  assign take     = strobe | ((mode == ssi_pkg::MODE_BYTE) & mid_byte);
  assign idx      = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (take) begin
      if (cnt_q == LAST_IDX) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ssi_rx_path.sv
`timescale 1ns/1ps
// Receive deserializer, LSB first.
module ssi_rx_path #(
  parameter int W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  ssi_pkg::strobe_mode_e mode,
  input  logic                  strobe,
  input  logic                  din,
  output logic                  done,
  output logic [W-1:0]          data
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

  logic          take;
  logic [CW-1:0] idx;
  logic [W-1:0]  sh_q;
  logic [W-1:0]  sh_nxt;

  ssi_slot_gate #(.W(W)) u_gate (
    .clk    (clk),
    .rst    (rst),
    .mode   (mode),
    .strobe (strobe),
    .take   (take),
    .idx    (idx)
  );

  assign sh_nxt = {din, sh_q[W-1:1]};
  assign done   = take & (idx == LAST_IDX);
  assign data   = sh_nxt;

  always_ff @(posedge clk) begin
    if (rst)       sh_q <= '0;
    else if (take) sh_q <= sh_nxt;
  end
endmodule

// File: rtl/ssi_rx_hold.sv
`timescale 1ns/1ps
// Holding register between the deserializer and the consumer.
module ssi_rx_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         done,
  input  logic [W-1:0] data,
  input  logic         ready,
  input  logic         clr,
  output logic [W-1:0] byte_out,
  output logic         valid,
  output logic         overrun
);
  logic [W-1:0] byte_q;
  logic         valid_q;
  logic         ovr_q;
  logic         accept;
  logic         drop;

  assign accept = valid_q & ready;
  assign drop   = done & valid_q & ~ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_q  <= '0;
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (done && !drop) begin
        byte_q  <= data;
        valid_q <= 1'b1;
      end else if (accept) begin
        valid_q <= 1'b0;
      end
      if (drop)     ovr_q <= 1'b1;
      else if (clr) ovr_q <= 1'b0;
    end
  end

  assign byte_out = byte_q;
  assign valid    = valid_q;
  assign overrun  = ovr_q;
endmodule

// File: rtl/ssi_tx_buf.sv
`timescale 1ns/1ps
// One-entry transmit buffer with valid/ready intake.
module ssi_tx_buf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] in_byte,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         consume,
  output logic         full,
  output logic [W-1:0] held
);
  logic         full_q;
  logic [W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      held_q <= '0;
    end else if (consume) begin
      full_q <= 1'b0;
    end else if (in_valid && !full_q) begin
      full_q <= 1'b1;
      held_q <= in_byte;
    end
  end

  assign in_ready = ~full_q;
  assign full     = full_q;
  assign held     = held_q;
endmodule

// File: rtl/ssi_tx_path.sv
`timescale 1ns/1ps
// Transmit serializer, LSB first, with all-ones fill on underrun.
module ssi_tx_path #(
  parameter int W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  ssi_pkg::strobe_mode_e mode,
  input  logic                  strobe,
  input  logic                  have_byte,
  input  logic [W-1:0]          next_byte,
  output logic                  consume,
  output logic                  line,
  output logic                  underrun
);
  localparam int CW = $clog2(W);

  logic          take;
  logic [CW-1:0] idx;
  logic          slot_start;
  logic [W-1:0]  sh_q;
  logic          line_q;
  logic          und_q;

  ssi_slot_gate #(.W(W)) u_gate (
    .clk    (clk),
    .rst    (rst),
    .mode   (mode),
    .strobe (strobe),
    .take   (take),
    .idx    (idx)
  );

  assign slot_start = take & (idx == '0);
  assign consume    = slot_start & have_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '1;
      line_q <= 1'b1;
      und_q  <= 1'b0;
    end else begin
      und_q <= 1'b0;
      if (slot_start) begin
        if (have_byte) begin
          line_q <= next_byte[0];
          sh_q   <= {1'b1, next_byte[W-1:1]};
        end else begin
          line_q <= 1'b1;
          sh_q   <= '1;
          und_q  <= 1'b1;
        end
      end else if (take) begin
        line_q <= sh_q[0];
        sh_q   <= {1'b1, sh_q[W-1:1]};
      end
    end
  end

  assign line     = line_q;
  assign underrun = und_q;
endmodule

// File: rtl/strobe_serial_if.sv
`timescale 1ns/1ps
// Strobe-qualified serial byte port: top level.
module strobe_serial_if #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         byte_mode,
  input  logic         rx_din,
  input  logic         rx_strobe,
  output logic [W-1:0] rx_byte,
  output logic         rx_valid,
  input  logic         rx_ready,
  input  logic         ovr_clear,
  output logic         rx_overrun,
  input  logic         tx_strobe,
  input  logic [W-1:0] tx_byte,
  input  logic         tx_valid,
  output logic         tx_ready,
  output logic         tx_line,
  output logic         tx_underrun
);
  ssi_pkg::strobe_mode_e mode;
  logic                  rx_done;
  logic [W-1:0]          rx_word;
  logic                  tx_consume;
  logic                  tx_full;
  logic [W-1:0]          tx_held;

  assign mode = byte_mode ? ssi_pkg::MODE_BYTE : ssi_pkg::MODE_PER_BIT;

  ssi_rx_path #(.W(W)) u_rx (
    .clk    (clk),
    .rst    (rst),
    .mode   (mode),
    .strobe (rx_strobe),
    .din    (rx_din),
    .done   (rx_done),
    .data   (rx_word)
  );

  ssi_rx_hold #(.W(W)) u_rx_hold (
    .clk      (clk),
    .rst      (rst),
    .done     (rx_done),
    .data     (rx_word),
    .ready    (rx_ready),
    .clr      (ovr_clear),
    .byte_out (rx_byte),
    .valid    (rx_valid),
    .overrun  (rx_overrun)
  );

  ssi_tx_buf #(.W(W)) u_tx_buf (
    .clk      (clk),
    .rst      (rst),
    .in_byte  (tx_byte),
    .in_valid (tx_valid),
    .in_ready (tx_ready),
    .consume  (tx_consume),
    .full     (tx_full),
    .held     (tx_held)
  );

  ssi_tx_path #(.W(W)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .strobe    (tx_strobe),
    .have_byte (tx_full),
    .next_byte (tx_held),
    .consume   (tx_consume),
    .line      (tx_line),
    .underrun  (tx_underrun)
  );
endmodule

// File: rtl/ssi_checker.sv
`timescale 1ns/1ps
// Port-level properties of the strobe-qualified serial byte port.
module ssi_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         byte_mode,
  input logic         rx_strobe,
  input logic         rx_ready,
  input logic         ovr_clear,
  input logic         rx_valid,
  input logic [W-1:0] rx_byte,
  input logic         rx_overrun,
  input logic         tx_valid,
  input logic         tx_ready,
  input logic         tx_strobe,
  input logic         tx_line,
  input logic         tx_underrun
);
  p_no_rise_unstrobed_r3: assert property (@(posedge clk) disable iff (rst)
    (!byte_mode && !rx_strobe) |=> !$rose(rx_valid));

  p_line_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!byte_mode && !tx_strobe) |=> $stable(tx_line));

  p_rx_wait_r7: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_byte)));

  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_overrun && !ovr_clear) |=> rx_overrun);

  p_tx_take_r9: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> !tx_ready);

  p_underrun_ones_r10: assert property (@(posedge clk) disable iff (rst)
    tx_underrun |-> tx_line);

  p_underrun_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    tx_underrun |=> !tx_underrun);
endmodule

bind strobe_serial_if ssi_checker #(.W(W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .byte_mode   (byte_mode),
  .rx_strobe   (rx_strobe),
  .rx_ready    (rx_ready),
  .ovr_clear   (ovr_clear),
  .rx_valid    (rx_valid),
  .rx_byte     (rx_byte),
  .rx_overrun  (rx_overrun),
  .tx_valid    (tx_valid),
  .tx_ready    (tx_ready),
  .tx_strobe   (tx_strobe),
  .tx_line     (tx_line),
  .tx_underrun (tx_underrun)
);

// File: tb/strobe_serial_if_test.sv
`timescale 1ns/1ps
module strobe_serial_if_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       byte_mode = 1'b0;
  logic       rx_din = 1'b0;
  logic       rx_strobe = 1'b0;
  logic [7:0] rx_byte;
  logic       rx_valid;
  logic       rx_ready = 1'b0;
  logic       ovr_clear = 1'b0;
  logic       rx_overrun;
  logic       tx_strobe = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic       tx_line;
  logic       tx_underrun;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  started = 1'b0;
  bit  ended = 1'b0;

  always #5 clk = ~clk;

  strobe_serial_if uut (
    .clk(clk), .rst(rst), .byte_mode(byte_mode),
    .rx_din(rx_din), .rx_strobe(rx_strobe), .rx_byte(rx_byte),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .ovr_clear(ovr_clear),
    .rx_overrun(rx_overrun), .tx_strobe(tx_strobe), .tx_byte(tx_byte),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_line(tx_line),
    .tx_underrun(tx_underrun)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int         m_rcnt;
  int         m_racc;
  logic [7:0] e_rx_byte;
  bit         e_rx_valid, e_ovr;
  bit         m_txq[$];
  bit         e_line, e_und, m_full;
  logic [7:0] m_held;

  always @(posedge clk) begin : model
    bit took, fin, load;
    int nb;
    started = 1'b1;
    if (rst) begin
      m_rcnt = 0; m_racc = 0; e_rx_byte = 8'h00; e_rx_valid = 0; e_ovr = 0;
      m_txq.delete(); e_line = 1; e_und = 0; m_full = 0; m_held = 8'h00;
    end else begin
      took = e_rx_valid && rx_ready;
      fin = 0; nb = 0;
      if (rx_strobe || (byte_mode && m_rcnt != 0)) begin
        m_racc = m_racc | (int'(rx_din) << m_rcnt);
        m_rcnt++;
        if (m_rcnt == 8) begin fin = 1; nb = m_racc; m_rcnt = 0; m_racc = 0; end
      end
      if (fin && e_rx_valid && !took) e_ovr = 1;
      else if (ovr_clear) e_ovr = 0;
      if (fin && (!e_rx_valid || took)) begin e_rx_byte = nb[7:0]; e_rx_valid = 1; end
      else if (took) e_rx_valid = 0;

      load = tx_valid && !m_full;
      e_und = 0;
      if (tx_strobe || (byte_mode && m_txq.size() != 0)) begin
        if (m_txq.size() == 0) begin
          if (m_full) begin
            for (int k = 0; k < 8; k++) m_txq.push_back(m_held[k]);
            m_full = 0;
          end else begin
            for (int k = 0; k < 8; k++) m_txq.push_back(1'b1);
            e_und = 1;
          end
        end
        e_line = m_txq.pop_front();
      end
      if (load) begin m_full = 1; m_held = tx_byte; end
    end
  end

  always @(negedge clk) begin
    if (started && !ended) begin
      chk("R2 rx_byte",     {24'd0, rx_byte}, {24'd0, e_rx_byte});
      chk("R3 rx_valid",    {31'd0, rx_valid}, {31'd0, e_rx_valid});
      chk("R8 rx_overrun",  {31'd0, rx_overrun}, {31'd0, e_ovr});
      chk("R4 tx_line",     {31'd0, tx_line}, {31'd0, e_line});
      chk("R9 tx_ready",    {31'd0, tx_ready}, {31'd0, !m_full});
      chk("R10 tx_underrun",{31'd0, tx_underrun}, {31'd0, e_und});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic rx_perbit(input logic [7:0] b, input int gap);
    for (int i = 0; i < 8; i++) begin
      rx_strobe = 1; rx_din = b[i]; cyc(1);
      rx_strobe = 0; rx_din = ~b[i]; cyc(gap);
    end
  endtask

  task automatic rx_bytemode(input logic [7:0] b, input bit strobe_all, input bit ready_last);
    for (int i = 0; i < 8; i++) begin
      rx_strobe = (i == 0) || strobe_all;
      rx_din = b[i];
      rx_ready = (i == 7) ? ready_last : 1'b0;
      cyc(1);
    end
    rx_strobe = 0; rx_ready = 0; rx_din = 0;
  endtask

  task automatic tx_load(input logic [7:0] b);
    tx_byte = b; tx_valid = 1; cyc(1); tx_valid = 0;
  endtask

  task automatic soak(input int n);
    for (int i = 0; i < n; i++) begin
      rx_strobe = ($urandom % 3) == 0;
      rx_din    = $urandom % 2;
      tx_strobe = ($urandom % 4) == 0;
      tx_valid  = $urandom % 2;
      tx_byte   = 8'($urandom);
      rx_ready  = ($urandom % 3) == 0;
      ovr_clear = ($urandom % 17) == 0;
      cyc(1);
    end
    rx_strobe = 0; tx_strobe = 0; tx_valid = 0; rx_ready = 0; ovr_clear = 0;
  endtask

  initial begin : watchdog
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    ended = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] got;
    cyc(3);
    chk("R1 tx_line",     {31'd0, tx_line}, 32'd1);
    chk("R1 tx_ready",    {31'd0, tx_ready}, 32'd1);
    chk("R1 rx_valid",    {31'd0, rx_valid}, 32'd0);
    chk("R1 rx_overrun",  {31'd0, rx_overrun}, 32'd0);
    chk("R1 tx_underrun", {31'd0, tx_underrun}, 32'd0);
    rst = 0; cyc(1);

    // per-bit receive with gaps and inverted filler data
    rx_perbit(8'hA5, 2);
    chk("R3 valid after 8th strobe", {31'd0, rx_valid}, 32'd1);
    chk("R2 lsb-first byte", {24'd0, rx_byte}, 32'hA5);
    rx_ready = 1; cyc(1); rx_ready = 0;
    chk("R7 taken", {31'd0, rx_valid}, 32'd0);

    // per-bit transmit
    tx_load(8'h5A);
    chk("R9 ready low after load", {31'd0, tx_ready}, 32'd0);
    got = 8'h00;
    for (int i = 0; i < 8; i++) begin
      tx_strobe = 1; cyc(1); tx_strobe = 0;
      got[i] = tx_line;
      cyc(2);
    end
    chk("R4 per-bit tx byte", {24'd0, got}, 32'h5A);
    chk("R9 ready after slot", {31'd0, tx_ready}, 32'd1);

    // empty slot
    tx_strobe = 1; cyc(1); tx_strobe = 0;
    chk("R10 underrun pulse", {31'd0, tx_underrun}, 32'd1);
    chk("R10 idle one", {31'd0, tx_line}, 32'd1);
    cyc(1);
    chk("R10 pulse ends", {31'd0, tx_underrun}, 32'd0);

    soak(1500);

    // byte-aligned mode
    rst = 1; byte_mode = 1; cyc(2); rst = 0; cyc(1);
    rx_bytemode(8'h3C, 0, 0);
    chk("R5 byte-mode rx", {24'd0, rx_byte}, 32'h3C);
    rx_bytemode(8'h22, 0, 1);
    chk("R7 swap byte", {24'd0, rx_byte}, 32'h22);
    chk("R7 swap valid", {31'd0, rx_valid}, 32'd1);
    chk("R7 swap no overrun", {31'd0, rx_overrun}, 32'd0);
    rx_ready = 1; cyc(1); rx_ready = 0;
    rx_bytemode(8'hC9, 1, 0);
    chk("R6 mid-byte strobes ignored", {24'd0, rx_byte}, 32'hC9);
    rx_bytemode(8'h77, 0, 0);
    chk("R8 overrun set", {31'd0, rx_overrun}, 32'd1);
    chk("R8 old byte kept", {24'd0, rx_byte}, 32'hC9);
    ovr_clear = 1; cyc(1); ovr_clear = 0;
    chk("R8 overrun cleared", {31'd0, rx_overrun}, 32'd0);
    rx_ready = 1; cyc(1); rx_ready = 0;

    tx_load(8'h96);
    tx_strobe = 1; cyc(1); tx_strobe = 0;
    got = 8'h00;
    got[0] = tx_line;
    for (int i = 1; i < 8; i++) begin
      cyc(1);
      got[i] = tx_line;
    end
    chk("R5 byte-mode tx", {24'd0, got}, 32'h96);

    soak(1500);
    cyc(2);
    ended = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule